// File: doc/BRIEF.md
# Shared Multi-Hart Translation Lookaside Buffer

This block caches virtual-to-physical page translations for a group of harts that share one set-associative array. Each stored entry carries three tag parts: a machine isolation value taken from the owning hart's isolation register, an effective address-space identifier, and the virtual page number. A lookup names the requesting hart, its ASID and a virtual page. One cycle later the block returns hit or miss, the physical page number and the permission bits.

Before an ASID is stored or compared, the value zero is renamed to a number that is unique to each hart: all-ones minus the hart number. Non-zero ASIDs are therefore shared by every hart with the same isolation value, while ASID 0 stays private to each hart. An external page walker writes entries through the fill port, and only valid page-table entries are kept. A flush port removes entries by isolation domain, optionally narrowed to one page, one ASID, or both.

A small bank of per-hart isolation registers is part of the block. Only the low `ISO_WBITS` bits of each register can be written. The remaining bits hold a per-hart constant given by parameter, so a designer can, for example, tie the high bits to a tile number.

Top module: `shared_tlb`

## Requirements
- R1: A lookup presented in cycle t is answered in cycle t+1: `rsp_valid` equals the previous cycle's `lk_valid`, and on a miss (or when no response is due) `rsp_hit`, `rsp_ppn` and `rsp_perm` are zero.
- R2: An entry never hits for a requester whose current isolation value differs from the value stored with the entry, whatever the ASIDs or the global bit.
- R3: A non-zero ASID filled by one hart hits for any hart with the same isolation value and the same ASID; a different non-zero ASID misses.
- R4: ASID 0 from hart h is treated as ASID (2^ASID_W − 1 − h). An ASID-0 entry of one hart misses for another hart's ASID 0, and it hits for a hart that presents that renamed value explicitly.
- R5: An entry filled with `fill_global` set hits for any ASID, given a matching isolation value and page.
- R6: A fill with `fill_pte_v` clear is discarded and leaves the array unchanged.
- R7: Isolation register bits [ISO_WBITS-1:0] are writable, and the upper bits always read the per-hart constant in `ISO_FIXED` (hart h at bits [h*ISO_W +: ISO_W]). Writable bits reset to zero. A write appears on `iso_rdata` in the cycle after it is made, and it governs the lookups, fills and flushes of later cycles.
- R8: The set index is `vpn[SET_W-1:0]`. A fill goes to the way that already holds the same isolation value, page and effective ASID; failing that, to the lowest-numbered invalid way; failing that, to the way named by the set's round-robin pointer. The pointer starts at 0 and advances by one on every accepted fill to that set.
- R9: A flush acts only on entries whose isolation value equals the flushing hart's. With neither selector set it removes every such entry. `fl_use_vpn` narrows it to the page `fl_vpn`. `fl_use_asid` narrows it to non-global entries with the renamed `fl_asid`, and global entries survive. With both selectors set, both conditions apply.
- R10: A lookup in the same cycle as an accepted fill that matches it hits, and returns the data of that fill.
- R11: A flush in the same cycle as a fill discards the fill. A lookup in the same cycle as a flush sees the contents from before the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iso_we | input | 1 | Isolation register write strobe |
| iso_whart | input | HART_W | Hart whose isolation register is written |
| iso_wdata | input | ISO_W | Write data (only writable bits are kept) |
| iso_rhart | input | HART_W | Hart whose isolation register is read |
| iso_rdata | output | ISO_W | Current isolation value of `iso_rhart` |
| lk_valid | input | 1 | Lookup request |
| lk_hart | input | HART_W | Requesting hart |
| lk_asid | input | ASID_W | Requester ASID |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Translation found |
| rsp_ppn | output | PPN_W | Physical page number |
| rsp_perm | output | PERM_W | Permission bits |
| fill_valid | input | 1 | Fill request from the walker |
| fill_pte_v | input | 1 | Valid bit of the page-table entry being filled |
| fill_global | input | 1 | Entry matches every ASID |
| fill_hart | input | HART_W | Hart on whose behalf the walk ran |
| fill_asid | input | ASID_W | ASID of that walk |
| fill_vpn | input | VPN_W | Virtual page number |
| fill_ppn | input | PPN_W | Physical page number |
| fill_perm | input | PERM_W | Permission bits |
| fl_valid | input | 1 | Flush request |
| fl_hart | input | HART_W | Hart issuing the flush |
| fl_use_asid | input | 1 | Restrict the flush to one ASID |
| fl_asid | input | ASID_W | ASID for a restricted flush |
| fl_use_vpn | input | 1 | Restrict the flush to one page |
| fl_vpn | input | VPN_W | Page for a restricted flush |

## Verification
The bench covers the tag rules at their edges:
- Two harts using ASID 0 on the same page. A design that skipped the renaming would leak one hart's translation to the other.
- A hart presenting the renamed value explicitly. A design that renamed to some other value would miss.
- Global entries tested against ASID-only flushes. Wrongly dropping them loses a translation that is still live.
- A flush from a hart in a different isolation domain. Ignoring the isolation value wipes entries that belong to another domain.

Nine fills into one set, followed by a refill of a tag already present, show whether eviction follows the invalid-first, round-robin and same-tag order; a wrong order evicts the wrong page. Same-cycle combinations are also driven: fill with lookup, flush with fill, and flush with lookup. A design that resolved any of these the other way returns a stale miss or keeps an entry it should have dropped.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Flush reach, encoded as {use_vpn, use_asid}
  typedef enum logic [1:0] {
    FL_ALL       = 2'b00,
    FL_ASID      = 2'b01,
    FL_PAGE      = 2'b10,
    FL_PAGE_ASID = 2'b11
  } flush_scope_e;
endpackage

// File: rtl/tlb_iso_regs.sv
module tlb_iso_regs #(
  parameter int HARTS     = 4,
  parameter int HART_W    = 2,
  parameter int ISO_W     = 4,
  parameter int ISO_WBITS = 2,
  parameter logic [HARTS*ISO_W-1:0] ISO_FIXED = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [HART_W-1:0]      whart,
  input  logic [ISO_W-1:0]       wdata,
  output logic [HARTS*ISO_W-1:0] iso_flat
);
  function automatic logic [ISO_W-1:0] build_mask();
    logic [ISO_W-1:0] m;
    for (int i = 0; i < ISO_W; i++) m[i] = (i < ISO_WBITS);
    return m;
  endfunction

  localparam logic [ISO_W-1:0] WMASK = build_mask();

  logic [ISO_W-1:0] iso_q [HARTS];

  for (genvar h = 0; h < HARTS; h++) begin : g_hart
    localparam logic [ISO_W-1:0] FIXED_H = ISO_FIXED[h*ISO_W +: ISO_W] & ~WMASK;
    always_ff @(posedge clk) begin
      if (rst) begin
        iso_q[h] <= FIXED_H;
      end else if (we && (whart == HART_W'(h))) begin
        iso_q[h] <= (wdata & WMASK) | FIXED_H;
      end
    end
    assign iso_flat[h*ISO_W +: ISO_W] = iso_q[h];
  end
endmodule

// File: rtl/tlb_set_match.sv
module tlb_set_match #(
  parameter int WAYS   = 8,
  parameter int ISO_W  = 4,
  parameter int ASID_W = 9,
  parameter int VPN_W  = 27
) (
  input  logic [WAYS-1:0]        row_v,
  input  logic [WAYS-1:0]        row_g,
  input  logic [WAYS*ISO_W-1:0]  row_iso,
  input  logic [WAYS*ASID_W-1:0] row_asid,
  input  logic [WAYS*VPN_W-1:0]  row_vpn,
  input  logic [ISO_W-1:0]       q_iso,
  input  logic [ASID_W-1:0]      q_asid,
  input  logic [VPN_W-1:0]       q_vpn,
  input  logic                   use_global,
  output logic [WAYS-1:0]        hits
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hits[w] = row_v[w]
                   && (row_iso[w*ISO_W +: ISO_W] == q_iso)
                   && (row_vpn[w*VPN_W +: VPN_W] == q_vpn)
                   && ((use_global && row_g[w]) || (row_asid[w*ASID_W +: ASID_W] == q_asid));
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int WAYS  = 8,
  parameter int WAY_W = 3
) (
  input  logic [WAYS-1:0]  same_tag,
  input  logic [WAYS-1:0]  occupied,
  input  logic [WAY_W-1:0] rr_ptr,
  output logic [WAY_W-1:0] way
);
  always_comb begin
    logic found;
    way   = rr_ptr;
    found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && same_tag[w]) begin
        way   = WAY_W'(w);
        found = 1'b1;
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !occupied[w]) begin
        way   = WAY_W'(w);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/shared_tlb.sv
module shared_tlb
  import tlb_pkg::*;
#(
  parameter int HARTS     = 4,
  parameter int HART_W    = (HARTS > 1) ? $clog2(HARTS) : 1,
  parameter int ASID_W    = 9,
  parameter int VPN_W     = 27,
  parameter int PPN_W     = 20,
  parameter int PERM_W    = 4,
  parameter int ISO_W     = 4,
  parameter int ISO_WBITS = 2,
  parameter logic [HARTS*ISO_W-1:0] ISO_FIXED = 16'h4400,
  parameter int WAYS      = 8,
  parameter int SETS      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iso_we,
  input  logic [HART_W-1:0] iso_whart,
  input  logic [ISO_W-1:0]  iso_wdata,
  input  logic [HART_W-1:0] iso_rhart,
  output logic [ISO_W-1:0]  iso_rdata,
  input  logic              lk_valid,
  input  logic [HART_W-1:0] lk_hart,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic [PERM_W-1:0] rsp_perm,
  input  logic              fill_valid,
  input  logic              fill_pte_v,
  input  logic              fill_global,
  input  logic [HART_W-1:0] fill_hart,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              fl_valid,
  input  logic [HART_W-1:0] fl_hart,
  input  logic              fl_use_asid,
  input  logic [ASID_W-1:0] fl_asid,
  input  logic              fl_use_vpn,
  input  logic [VPN_W-1:0]  fl_vpn
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [ASID_W-1:0] ASID_TOP = '1;

  // ASID 0 is renamed per hart; other values pass through unchanged
  function automatic logic [ASID_W-1:0] eff_asid(input logic [ASID_W-1:0] a,
                                                 input logic [HART_W-1:0] h);
    return (a == '0) ? (ASID_TOP - ASID_W'(h)) : a;
  endfunction

  // ---------------- isolation registers ----------------
  logic [HARTS*ISO_W-1:0] iso_flat;

  tlb_iso_regs #(
    .HARTS(HARTS), .HART_W(HART_W), .ISO_W(ISO_W),
    .ISO_WBITS(ISO_WBITS), .ISO_FIXED(ISO_FIXED)
  ) u_iso (
    .clk(clk), .rst(rst), .we(iso_we), .whart(iso_whart),
    .wdata(iso_wdata), .iso_flat(iso_flat)
  );

  assign iso_rdata = iso_flat[int'(iso_rhart)*ISO_W +: ISO_W];

  // ---------------- entry storage ----------------
  logic [WAYS-1:0]   e_v    [SETS];
  logic [WAYS-1:0]   e_g    [SETS];
  logic [ISO_W-1:0]  e_iso  [SETS][WAYS];
  logic [ASID_W-1:0] e_asid [SETS][WAYS];
  logic [VPN_W-1:0]  e_vpn  [SETS][WAYS];
  logic [PPN_W-1:0]  e_ppn  [SETS][WAYS];
  logic [PERM_W-1:0] e_perm [SETS][WAYS];
  logic [WAY_W-1:0]  rr_ptr [SETS];

  // ---------------- request decode ----------------
  logic [SET_W-1:0]  lk_set, fill_set;
  logic [ISO_W-1:0]  lk_iso, fill_iso, fl_iso;
  logic [ASID_W-1:0] lk_eff, fill_eff, fl_eff;
  logic              fill_ok;
  flush_scope_e      fl_scope;

  assign lk_set   = lk_vpn[SET_W-1:0];
  assign fill_set = fill_vpn[SET_W-1:0];
  assign lk_iso   = iso_flat[int'(lk_hart)*ISO_W +: ISO_W];
  assign fill_iso = iso_flat[int'(fill_hart)*ISO_W +: ISO_W];
  assign fl_iso   = iso_flat[int'(fl_hart)*ISO_W +: ISO_W];
  assign lk_eff   = eff_asid(lk_asid, lk_hart);
  assign fill_eff = eff_asid(fill_asid, fill_hart);
  assign fl_eff   = eff_asid(fl_asid, fl_hart);
  assign fill_ok  = fill_valid && fill_pte_v && !fl_valid;
  assign fl_scope = flush_scope_e'({fl_use_vpn, fl_use_asid});

  // ---------------- row gathering ----------------
  logic [WAYS*ISO_W-1:0]  lk_row_iso,  fi_row_iso;
  logic [WAYS*ASID_W-1:0] lk_row_asid, fi_row_asid;
  logic [WAYS*VPN_W-1:0]  lk_row_vpn,  fi_row_vpn;

  for (genvar w = 0; w < WAYS; w++) begin : g_row
    assign lk_row_iso [w*ISO_W  +: ISO_W]  = e_iso [lk_set][w];
    assign lk_row_asid[w*ASID_W +: ASID_W] = e_asid[lk_set][w];
    assign lk_row_vpn [w*VPN_W  +: VPN_W]  = e_vpn [lk_set][w];
    assign fi_row_iso [w*ISO_W  +: ISO_W]  = e_iso [fill_set][w];
    assign fi_row_asid[w*ASID_W +: ASID_W] = e_asid[fill_set][w];
    assign fi_row_vpn [w*VPN_W  +: VPN_W]  = e_vpn [fill_set][w];
  end

  // ---------------- lookup ----------------
  logic [WAYS-1:0]  lk_hits;
  logic [WAY_W-1:0] hit_way;
  logic             byp_hit;

  tlb_set_match #(.WAYS(WAYS), .ISO_W(ISO_W), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_lk_match (
    .row_v(e_v[lk_set]), .row_g(e_g[lk_set]),
    .row_iso(lk_row_iso), .row_asid(lk_row_asid), .row_vpn(lk_row_vpn),
    .q_iso(lk_iso), .q_asid(lk_eff), .q_vpn(lk_vpn),
    .use_global(1'b1), .hits(lk_hits)
  );

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (lk_hits[w]) hit_way = WAY_W'(w);
    end
  end

  // a fill accepted this cycle is visible to a lookup in the same cycle
  assign byp_hit = fill_ok && (fill_iso == lk_iso) && (fill_vpn == lk_vpn)
                && (fill_global || (fill_eff == lk_eff));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
      rsp_perm  <= '0;
      if (lk_valid && byp_hit) begin
        rsp_hit  <= 1'b1;
        rsp_ppn  <= fill_ppn;
        rsp_perm <= fill_perm;
      end else if (lk_valid && (|lk_hits)) begin
        rsp_hit  <= 1'b1;
        rsp_ppn  <= e_ppn[lk_set][hit_way];
        rsp_perm <= e_perm[lk_set][hit_way];
      end
    end
  end

  // ---------------- fill victim ----------------
  logic [WAYS-1:0]  fi_same;
  logic [WAY_W-1:0] vic_way;

  tlb_set_match #(.WAYS(WAYS), .ISO_W(ISO_W), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_fi_match (
    .row_v(e_v[fill_set]), .row_g(e_g[fill_set]),
    .row_iso(fi_row_iso), .row_asid(fi_row_asid), .row_vpn(fi_row_vpn),
    .q_iso(fill_iso), .q_asid(fill_eff), .q_vpn(fill_vpn),
    .use_global(1'b0), .hits(fi_same)
  );

  tlb_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .same_tag(fi_same), .occupied(e_v[fill_set]),
    .rr_ptr(rr_ptr[fill_set]), .way(vic_way)
  );

  // ---------------- flush match ----------------
  logic [WAYS-1:0] fl_kill [SETS];

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        unique case (fl_scope)
          FL_ALL:  fl_kill[s][w] = e_v[s][w] && (e_iso[s][w] == fl_iso);
          FL_ASID: fl_kill[s][w] = e_v[s][w] && (e_iso[s][w] == fl_iso)
                                && !e_g[s][w] && (e_asid[s][w] == fl_eff);
          FL_PAGE: fl_kill[s][w] = e_v[s][w] && (e_iso[s][w] == fl_iso)
                                && (e_vpn[s][w] == fl_vpn);
          default: fl_kill[s][w] = e_v[s][w] && (e_iso[s][w] == fl_iso)
                                && (e_vpn[s][w] == fl_vpn)
                                && !e_g[s][w] && (e_asid[s][w] == fl_eff);
        endcase
      end
    end
  end

  // ---------------- state update ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        e_v[s]    <= '0;
        rr_ptr[s] <= '0;
      end
    end else if (fl_valid) begin
      for (int s = 0; s < SETS; s++) begin
        e_v[s] <= e_v[s] & ~fl_kill[s];
      end
    end else if (fill_ok) begin
      e_v[fill_set][vic_way] <= 1'b1;
      rr_ptr[fill_set]       <= rr_ptr[fill_set] + WAY_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ok) begin
      e_g   [fill_set][vic_way] <= fill_global;
      e_iso [fill_set][vic_way] <= fill_iso;
      e_asid[fill_set][vic_way] <= fill_eff;
      e_vpn [fill_set][vic_way] <= fill_vpn;
      e_ppn [fill_set][vic_way] <= fill_ppn;
      e_perm[fill_set][vic_way] <= fill_perm;
    end
  end
endmodule

// File: rtl/shared_tlb_chk.sv
module shared_tlb_chk #(
  parameter int HARTS     = 4,
  parameter int HART_W    = 2,
  parameter int ISO_W     = 4,
  parameter int ISO_WBITS = 2,
  parameter logic [HARTS*ISO_W-1:0] ISO_FIXED = '0,
  parameter int PPN_W     = 20,
  parameter int PERM_W    = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [PPN_W-1:0]  rsp_ppn,
  input logic [PERM_W-1:0] rsp_perm,
  input logic              iso_we,
  input logic [HART_W-1:0] iso_rhart,
  input logic [ISO_W-1:0]  iso_rdata
);
  function automatic logic [ISO_W-1:0] build_mask();
    logic [ISO_W-1:0] m;
    for (int i = 0; i < ISO_W; i++) m[i] = (i < ISO_WBITS);
    return m;
  endfunction

  localparam logic [ISO_W-1:0] WMASK = build_mask();

  logic chk_live;
  always_ff @(posedge clk) chk_live <= !rst;

  logic [ISO_W-1:0] fixed_sel;
  assign fixed_sel = ISO_FIXED[int'(iso_rhart)*ISO_W +: ISO_W];

  AST_RSP_TRACKS_REQ: assert property (@(posedge clk) disable iff (rst)
    chk_live |-> (rsp_valid == $past(lk_valid))); // R1

  AST_MISS_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> ((rsp_ppn == '0) && (rsp_perm == '0))); // R1

  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_hit && (rsp_ppn == '0))); // R1

  AST_ISO_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
    chk_live |-> ((iso_rdata & ~WMASK) == (fixed_sel & ~WMASK))); // R7

  AST_ISO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (chk_live && !$past(iso_we) && $stable(iso_rhart)) |-> $stable(iso_rdata)); // R7
endmodule

bind shared_tlb shared_tlb_chk #(
  .HARTS(HARTS), .HART_W(HART_W), .ISO_W(ISO_W), .ISO_WBITS(ISO_WBITS),
  .ISO_FIXED(ISO_FIXED), .PPN_W(PPN_W), .PERM_W(PERM_W)
) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm),
  .iso_we(iso_we), .iso_rhart(iso_rhart), .iso_rdata(iso_rdata)
);

// File: tb/shared_tlb_test.sv
module shared_tlb_test;
  localparam int H  = 4;
  localparam int HW = 2;
  localparam int AW = 9;
  localparam int VW = 27;
  localparam int PW = 20;
  localparam int RW = 4;
  localparam int IW = 4;
  localparam int IWB = 2;
  localparam int W  = 8;
  localparam int S  = 16;
  localparam logic [H*IW-1:0] FIX = 16'h4400;
  localparam logic [IW-1:0] MASK = 4'b0011;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst;
  logic iso_we; logic [HW-1:0] iso_whart; logic [IW-1:0] iso_wdata;
  logic [HW-1:0] iso_rhart; logic [IW-1:0] iso_rdata;
  logic lk_valid; logic [HW-1:0] lk_hart; logic [AW-1:0] lk_asid; logic [VW-1:0] lk_vpn;
  logic rsp_valid, rsp_hit; logic [PW-1:0] rsp_ppn; logic [RW-1:0] rsp_perm;
  logic fill_valid, fill_pte_v, fill_global; logic [HW-1:0] fill_hart;
  logic [AW-1:0] fill_asid; logic [VW-1:0] fill_vpn; logic [PW-1:0] fill_ppn; logic [RW-1:0] fill_perm;
  logic fl_valid; logic [HW-1:0] fl_hart; logic fl_use_asid; logic [AW-1:0] fl_asid;
  logic fl_use_vpn; logic [VW-1:0] fl_vpn;

  shared_tlb #(
    .HARTS(H), .HART_W(HW), .ASID_W(AW), .VPN_W(VW), .PPN_W(PW), .PERM_W(RW),
    .ISO_W(IW), .ISO_WBITS(IWB), .ISO_FIXED(FIX), .WAYS(W), .SETS(S)
  ) uut (.*);

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // behavioural reference model
  bit            mv   [S][W];
  bit            mg   [S][W];
  logic [IW-1:0] miso [S][W];
  logic [AW-1:0] masid[S][W];
  logic [VW-1:0] mvpn [S][W];
  logic [PW-1:0] mppn [S][W];
  logic [RW-1:0] mperm[S][W];
  int            mptr [S];
  logic [IW-1:0] misor[H];

  function automatic logic [AW-1:0] remap(input logic [AW-1:0] a, input int h);
    if (a == 0) return AW'((1 << AW) - 1 - h);
    return a;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    iso_we = 0; iso_whart = 0; iso_wdata = 0;
    lk_valid = 0; lk_hart = 0; lk_asid = 0; lk_vpn = 0;
    fill_valid = 0; fill_pte_v = 0; fill_global = 0; fill_hart = 0;
    fill_asid = 0; fill_vpn = 0; fill_ppn = 0; fill_perm = 0;
    fl_valid = 0; fl_hart = 0; fl_use_asid = 0; fl_asid = 0; fl_use_vpn = 0; fl_vpn = 0;
  endtask

  task automatic model_reset();
    for (int s = 0; s < S; s++) begin
      mptr[s] = 0;
      for (int w = 0; w < W; w++) mv[s][w] = 0;
    end
    for (int h = 0; h < H; h++) misor[h] = FIX[h*IW +: IW] & ~MASK;
  endtask

  // one clock: predict from the model, advance model, compare outputs
  task automatic step(input string req);
    bit exp_v, exp_hit, fok;
    logic [PW-1:0] exp_ppn; logic [RW-1:0] exp_perm;
    logic [IW-1:0] li, fi; logic [AW-1:0] le, fe;
    int ls, fs, vic;
    exp_v = lk_valid; exp_hit = 0; exp_ppn = 0; exp_perm = 0;
    fok = fill_valid && fill_pte_v && !fl_valid;
    fi = misor[fill_hart]; fe = remap(fill_asid, fill_hart); fs = int'(fill_vpn) % S;
    if (lk_valid) begin
      li = misor[lk_hart]; le = remap(lk_asid, lk_hart); ls = int'(lk_vpn) % S;
      if (fok && fi == li && fill_vpn == lk_vpn && (fill_global || fe == le)) begin
        exp_hit = 1; exp_ppn = fill_ppn; exp_perm = fill_perm;
      end else begin
        for (int w = W - 1; w >= 0; w--)
          if (mv[ls][w] && miso[ls][w] == li && mvpn[ls][w] == lk_vpn && (mg[ls][w] || masid[ls][w] == le)) begin
            exp_hit = 1; exp_ppn = mppn[ls][w]; exp_perm = mperm[ls][w];
          end
      end
    end
    if (fl_valid) begin
      for (int s = 0; s < S; s++)
        for (int w = 0; w < W; w++)
          if (mv[s][w] && miso[s][w] == misor[fl_hart]
              && (!fl_use_vpn || mvpn[s][w] == fl_vpn)
              && (!fl_use_asid || (!mg[s][w] && masid[s][w] == remap(fl_asid, fl_hart))))
            mv[s][w] = 0;
    end else if (fok) begin
      vic = -1;
      for (int w = 0; w < W; w++)
        if (vic < 0 && mv[fs][w] && miso[fs][w] == fi && mvpn[fs][w] == fill_vpn && masid[fs][w] == fe) vic = w;
      for (int w = 0; w < W; w++)
        if (vic < 0 && !mv[fs][w]) vic = w;
      if (vic < 0) vic = mptr[fs];
      mptr[fs] = (mptr[fs] + 1) % W;
      mv[fs][vic] = 1; mg[fs][vic] = fill_global; miso[fs][vic] = fi; masid[fs][vic] = fe;
      mvpn[fs][vic] = fill_vpn; mppn[fs][vic] = fill_ppn; mperm[fs][vic] = fill_perm;
    end
    if (iso_we) misor[iso_whart] = (iso_wdata & MASK) | (FIX[int'(iso_whart)*IW +: IW] & ~MASK);
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == exp_v, req, "rsp_valid", 64'(rsp_valid), 64'(exp_v));
    if (exp_v) begin
      chk(rsp_hit == exp_hit, req, "rsp_hit", 64'(rsp_hit), 64'(exp_hit));
      chk(rsp_ppn == exp_ppn, req, "rsp_ppn", 64'(rsp_ppn), 64'(exp_ppn));
      chk(rsp_perm == exp_perm, req, "rsp_perm", 64'(rsp_perm), 64'(exp_perm));
    end
    idle_inputs();
  endtask

  task automatic set_lk(input int h, input int a, input logic [VW-1:0] v);
    lk_valid = 1; lk_hart = HW'(h); lk_asid = AW'(a); lk_vpn = v;
  endtask

  task automatic set_fill(input int h, input int a, input logic [VW-1:0] v,
                          input logic [PW-1:0] p, input logic [RW-1:0] pm, input bit g, input bit pv);
    fill_valid = 1; fill_hart = HW'(h); fill_asid = AW'(a); fill_vpn = v;
    fill_ppn = p; fill_perm = pm; fill_global = g; fill_pte_v = pv;
  endtask

  task automatic set_flush(input int h, input bit uv, input logic [VW-1:0] v, input bit ua, input int a);
    fl_valid = 1; fl_hart = HW'(h); fl_use_vpn = uv; fl_vpn = v; fl_use_asid = ua; fl_asid = AW'(a);
  endtask

  task automatic lookup(input int h, input int a, input logic [VW-1:0] v, input string req);
    set_lk(h, a, v); step(req);
  endtask

  task automatic fill(input int h, input int a, input logic [VW-1:0] v, input logic [PW-1:0] p,
                      input logic [RW-1:0] pm, input bit g, input bit pv, input string req);
    set_fill(h, a, v, p, pm, g, pv); step(req);
  endtask

  task automatic chk_iso(input int h, input logic [IW-1:0] exp, input string req);
    iso_rhart = HW'(h);
    #1;
    chk(iso_rdata == exp, req, "iso_rdata", 64'(iso_rdata), 64'(exp));
  endtask

  localparam logic [VW-1:0] VA = 27'h100;
  localparam logic [VW-1:0] VB = 27'h211;
  localparam logic [VW-1:0] VC = 27'h322;
  localparam logic [VW-1:0] VD = 27'h433;
  localparam logic [VW-1:0] VE = 27'h544;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    iso_rhart = 0;
    rst = 1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk(rsp_valid == 0, "R1", "reset rsp_valid", 64'(rsp_valid), 0);
    chk(rsp_hit == 0, "R1", "reset rsp_hit", 64'(rsp_hit), 0);
    // R7: reset values, fixed upper bits per hart
    chk_iso(0, 4'h0, "R7"); chk_iso(1, 4'h0, "R7");
    chk_iso(2, 4'h4, "R7"); chk_iso(3, 4'h4, "R7");
    step("R1");
    lookup(0, 5, VA, "R1");
    fill(0, 5, VA, 20'h11111, 4'h3, 0, 1, "R8");
    lookup(1, 5, VA, "R3");
    lookup(0, 6, VA, "R3");
    lookup(2, 5, VA, "R2");
    // global entry
    fill(0, 7, VB, 20'h22222, 4'h5, 1, 1, "R5");
    lookup(1, 77, VB, "R5");
    lookup(2, 7, VB, "R2");
    // ASID 0 privacy and renaming
    fill(0, 0, VC, 20'h33333, 4'h1, 0, 1, "R4");
    lookup(1, 0, VC, "R4");
    lookup(0, 0, VC, "R4");
    lookup(1, 511, VC, "R4");
    fill(1, 0, VC, 20'h44444, 4'h2, 0, 1, "R4");
    lookup(0, 0, VC, "R4");
    lookup(1, 0, VC, "R4");
    // invalid PTE dropped
    fill(1, 5, VD, 20'h0BAD0, 4'hF, 0, 0, "R6");
    lookup(1, 5, VD, "R6");
    // same-cycle fill and lookup
    set_fill(1, 12, VD, 20'h55555, 4'h6, 0, 1); set_lk(0, 12, VD); step("R10");
    lookup(2, 12, VD, "R10");
    // flush beats fill
    set_fill(1, 13, VE, 20'h66666, 4'h7, 0, 1); set_flush(1, 1, 27'h999, 0, 0); step("R11");
    lookup(1, 13, VE, "R11");
    // lookup sees pre-flush contents
    set_flush(0, 1, VA, 1, 5); set_lk(1, 5, VA); step("R11");
    lookup(1, 5, VA, "R9");
    fill(0, 5, VA, 20'h11112, 4'h3, 0, 1, "R9");
    // ASID flush keeps globals
    set_flush(0, 0, 0, 1, 7); step("R9");
    lookup(1, 7, VB, "R9");
    // page flush removes global
    set_flush(1, 1, VB, 0, 0); step("R9");
    lookup(0, 7, VB, "R9");
    // whole flush from other domain leaves iso 0 entries
    fill(2, 21, VE, 20'h77777, 4'h8, 0, 1, "R9");
    lookup(3, 21, VE, "R3");
    set_flush(2, 0, 0, 0, 0); step("R9");
    lookup(2, 21, VE, "R9");
    lookup(0, 5, VA, "R9");
    // page+ASID flush with two ASIDs on one page
    fill(1, 30, VD, 20'h12345, 4'h9, 0, 1, "R9");
    set_flush(0, 1, VD, 1, 30); step("R9");
    lookup(1, 30, VD, "R9");
    lookup(1, 12, VD, "R9");
    // isolation register writes
    iso_we = 1; iso_whart = 0; iso_wdata = 4'hF; step("R7");
    chk_iso(0, 4'h3, "R7");
    iso_we = 1; iso_whart = 2; iso_wdata = 4'hB; step("R7");
    chk_iso(2, 4'h7, "R7");
    chk_iso(1, 4'h0, "R7");
    lookup(0, 5, VA, "R2");
    lookup(1, 5, VA, "R2");
    // replacement within one set
    for (int k = 1; k <= 9; k++) fill(1, 9, VW'(k * S + 6), PW'(k), 4'h1, 0, 1, "R8");
    for (int k = 1; k <= 9; k++) lookup(3 - 2, 9, VW'(k * S + 6), "R8");
    fill(1, 9, VW'(5 * S + 6), 20'h00055, 4'h2, 0, 1, "R8");
    for (int k = 2; k <= 9; k++) lookup(1, 9, VW'(k * S + 6), "R8");
    fill(1, 9, VW'(10 * S + 6), 20'h000AA, 4'h3, 0, 1, "R8");
    for (int k = 2; k <= 10; k++) lookup(0 + 1, 9, VW'(k * S + 6), "R8");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule